// File: doc/BRIEF.md
# Flash Write Status Generator

This block produces the read data of a flash device while an internal program or erase operation is running. The command decoder gives it a one-cycle start pulse, an operation code and the word being programmed. The block then stays busy for a set number of clock cycles, which depends on the operation. While it is busy, every read returns a status word in place of array contents. When the count runs out, the block pulses a completion flag for one cycle and returns to passing array data through.

The status word carries two indicators. The polarity indicator on bit 7 returns the inverse of the programmed bit 7 during a program, and 0 during any erase. The activity indicator on bit 6 inverts after every read strobe taken while busy. Software detects completion by checking that bit 7 shows true data, or that two reads in a row return the same bit 6. No separate status register is needed.

Top module: `flash_wstat_gen`

## Requirements
- R1: After reset, `busy_o` and `done_o` are 0 and the bit 6 indicator holds 0.
- R2: A `start_i` pulse seen while idle raises `busy_o` in the next cycle. `busy_o` then stays high for exactly N cycles, where N is `PROG_CYCLES` for `op_i` = 0 (program), `BLK_CYCLES` for `op_i` = 1 (sector or block erase), and `CHIP_CYCLES` for `op_i` = 2 or 3 (chip erase).
- R3: `start_i` asserted while busy is ignored: the remaining busy time and the captured operation and data are unchanged.
- R4: While a program is busy, `rd_data_o[7]` is the complement of bit 7 of the `prog_word_i` captured with the start.
- R5: While an erase is busy, `rd_data_o[7]` is 0.
- R6: While busy, `rd_data_o[6]` shows the indicator flop. Each cycle in which `rd_i` is high while busy inverts it for the following cycle.
- R7: While idle, the indicator ignores `rd_i` and keeps its value. The next operation starts from that held value.
- R8: While busy, every `rd_data_o` bit other than 7 and 6 reads 0.
- R9: While idle, `rd_data_o` equals `array_data_i`, so the true data, including an erased FFFFh, appears as soon as busy falls.
- R10: `done_o` is high for exactly one cycle, the cycle after the last busy cycle, and `busy_o` is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle start of an internal operation |
| op_i | input | 2 | Operation: 0 program, 1 sector/block erase, 2 or 3 chip erase |
| prog_word_i | input | DATA_W | Word being programmed, captured with the start |
| rd_i | input | 1 | Read strobe, one per read access |
| array_data_i | input | DATA_W | Data read from the array |
| rd_data_o | output | DATA_W | Read data to the host |
| busy_o | output | 1 | Internal operation running |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
A wrong busy count shows up on `busy_o` and `done_o` in the cycle where the busy period should have ended. It also shows on `rd_data_o`, which switches to array data one cycle too early or too late. A corrupted indicator flop or a wrongly captured data bit shows up on the very next read, in bit 6 or bit 7. A start that is wrongly accepted while busy stretches the busy period, and the bench checks the busy flag in every cycle. The bench carries the indicator's value across several operations with idle reads in between, so a flop that does not hold its value is caught at the next operation's first read.

// File: rtl/flash_wstat_pkg.sv
package flash_wstat_pkg;
    localparam logic [1:0] OP_PROG      = 2'd0;
    localparam logic [1:0] OP_BLK_ERASE = 2'd1;

    typedef struct packed {
        logic pol_bit;
        logic is_erase;
    } cap_t;
endpackage

// File: rtl/wsg_busy_timer.sv
module wsg_busy_timer
    import flash_wstat_pkg::*;
#(
    parameter int PROG_CYCLES = 28,
    parameter int BLK_CYCLES  = 360,
    parameter int CHIP_CYCLES = 1400
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [1:0] op_i,
    output logic       busy_o,
    output logic       done_o,
    output logic       accept_o
);
    localparam int MAXC  = (PROG_CYCLES > BLK_CYCLES) ?
                           ((PROG_CYCLES > CHIP_CYCLES) ? PROG_CYCLES : CHIP_CYCLES) :
                           ((BLK_CYCLES > CHIP_CYCLES) ? BLK_CYCLES : CHIP_CYCLES);
    localparam int CNT_W = (MAXC > 1) ? $clog2(MAXC) : 1;
    localparam logic [CNT_W-1:0] LD_PROG = CNT_W'(PROG_CYCLES - 1);
    localparam logic [CNT_W-1:0] LD_BLK  = CNT_W'(BLK_CYCLES - 1);
    localparam logic [CNT_W-1:0] LD_CHIP = CNT_W'(CHIP_CYCLES - 1);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t st_d, st_q;
    logic acc_d;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        acc_d     = 1'b0;
        if (st_q.busy) begin
            if (st_q.cnt == '0) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end else if (start_i) begin
            acc_d     = 1'b1;
            st_d.busy = 1'b1;
            if (op_i == OP_PROG)          st_d.cnt = LD_PROG;
            else if (op_i == OP_BLK_ERASE) st_d.cnt = LD_BLK;
            else                           st_d.cnt = LD_CHIP;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o   = st_q.busy;
    assign done_o   = st_q.done;
    assign accept_o = acc_d;

    // R10: completion pulse follows the final busy cycle
    a_r10_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |-> (!st_q.busy && $past(st_q.busy)));

    // R3: a start during busy neither reloads nor stalls the count
    a_r3_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && start_i && st_q.cnt != '0) |=>
        (st_q.busy && st_q.cnt == CNT_W'($past(st_q.cnt) - 1'b1)));

    // R2: remaining count never exceeds the longest period
    a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> (int'(st_q.cnt) < MAXC));
endmodule

// File: rtl/wsg_toggle_bit.sv
module wsg_toggle_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic busy_i,
    input  logic rd_i,
    output logic tog_o
);
    logic tog_d, tog_q;

    always_comb begin
        tog_d = tog_q;
        if (busy_i && rd_i) tog_d = ~tog_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tog_q <= 1'b0;
        else        tog_q <= tog_d;
    end

    assign tog_o = tog_q;

    // R6: a busy read inverts the indicator
    a_r6_flip_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && rd_i) |=> (tog_q != $past(tog_q)));

    // R7: idle cycles keep the indicator
    a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_i |=> $stable(tog_q));
endmodule

// File: rtl/wsg_read_mux.sv
module wsg_read_mux
    import flash_wstat_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept_i,
    input  logic [1:0]        op_i,
    input  logic              prog_bit7_i,
    input  logic              busy_i,
    input  logic              tog_i,
    input  logic [DATA_W-1:0] array_i,
    output logic [DATA_W-1:0] rd_o
);
    cap_t cap_d, cap_q;

    always_comb begin
        cap_d = cap_q;
        if (accept_i) begin
            cap_d.pol_bit  = prog_bit7_i;
            cap_d.is_erase = (op_i != OP_PROG);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    always_comb begin
        if (busy_i) begin
            rd_o    = '0;
            rd_o[7] = cap_q.is_erase ? 1'b0 : ~cap_q.pol_bit;
            rd_o[6] = tog_i;
        end else begin
            rd_o = array_i;
        end
    end

    // R3: captured operation stays fixed while busy
    a_r3_capture_stable: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> $stable(cap_q));
endmodule

// File: rtl/flash_wstat_gen.sv
module flash_wstat_gen
    import flash_wstat_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int PROG_CYCLES = 28,
    parameter int BLK_CYCLES  = 360,
    parameter int CHIP_CYCLES = 1400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [1:0]        op_i,
    input  logic [DATA_W-1:0] prog_word_i,
    input  logic              rd_i,
    input  logic [DATA_W-1:0] array_data_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              busy_o,
    output logic              done_o
);
    logic busy_w, done_w, accept_w, tog_w;

    wsg_busy_timer #(
        .PROG_CYCLES(PROG_CYCLES),
        .BLK_CYCLES (BLK_CYCLES),
        .CHIP_CYCLES(CHIP_CYCLES)
    ) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .op_i    (op_i),
        .busy_o  (busy_w),
        .done_o  (done_w),
        .accept_o(accept_w)
    );

    wsg_toggle_bit toggle_i (
        .clk   (clk),
        .rst_n (rst_n),
        .busy_i(busy_w),
        .rd_i  (rd_i),
        .tog_o (tog_w)
    );

    wsg_read_mux #(.DATA_W(DATA_W)) mux_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept_i   (accept_w),
        .op_i       (op_i),
        .prog_bit7_i(prog_word_i[7]),
        .busy_i     (busy_w),
        .tog_i      (tog_w),
        .array_i    (array_data_i),
        .rd_o       (rd_data_o)
    );

    assign busy_o = busy_w;
    assign done_o = done_w;

    // R2: an accepted start is followed by busy
    a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> busy_o);

    // R8: status word leaves the unused bits at zero
    a_r8_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (rd_data_o[5:0] == 6'd0));

    // R10: completion and busy are never high together
    a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o));
endmodule

// File: tb/flash_wstat_gen_tb_top.sv
module flash_wstat_gen_tb_top;
    localparam int DW   = 16;
    localparam int NPRG = 28;
    localparam int NBLK = 360;
    localparam int NCHP = 1400;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [1:0]    op_i = 2'd0;
    logic [DW-1:0] prog_word_i = '0;
    logic          rd_i = 1'b0;
    logic [DW-1:0] array_data_i = '0;
    logic [DW-1:0] rd_data_o;
    logic          busy_o, done_o;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    bit exp_tog = 1'b0;

    always #2 clk = ~clk;

    flash_wstat_gen #(
        .DATA_W(DW), .PROG_CYCLES(NPRG), .BLK_CYCLES(NBLK), .CHIP_CYCLES(NCHP)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
        .prog_word_i(prog_word_i), .rd_i(rd_i), .array_data_i(array_data_i),
        .rd_data_o(rd_data_o), .busy_o(busy_o), .done_o(done_o)
    );

    function automatic int dur_of(input logic [1:0] op);
        if (op == 2'd0) return NPRG;
        if (op == 2'd1) return NBLK;
        return NCHP;
    endfunction

    function automatic logic [DW-1:0] status_of(input logic [1:0] op,
                                                 input logic [DW-1:0] w,
                                                 input bit tog);
        logic [DW-1:0] s;
        s    = '0;
        s[7] = (op == 2'd0) ? ~w[7] : 1'b0;
        s[6] = tog;
        return s;
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // Idle cycles with random reads: pass-through and held indicator (R7, R9)
    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rd_i = 1'($urandom);
            array_data_i = DW'($urandom);
            #1;
            check(rd_data_o == array_data_i, "R9 idle passthrough", rd_data_o, array_data_i);
            check(!busy_o, "R7 idle busy low", busy_o, 0);
        end
        @(negedge clk);
        rd_i = 1'b0;
    endtask

    task automatic run_op(input logic [1:0] op, input logic [DW-1:0] w, input bit poke);
        int n;
        n = dur_of(op);
        @(negedge clk);
        start_i = 1'b1; op_i = op; prog_word_i = w; rd_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 1; i <= n; i++) begin
            bit r;
            r = 1'($urandom);
            rd_i = r;
            array_data_i = DW'($urandom);
            if (poke && (i % 5 == 2)) begin
                start_i = 1'b1;
                op_i = 2'd0;
                prog_word_i = ~w;
            end else begin
                start_i = 1'b0;
                op_i = 2'($urandom);
                prog_word_i = DW'($urandom);
            end
            #1;
            check(busy_o == 1'b1, "R2 busy during period", busy_o, 1);
            check(done_o == 1'b0, "R10 no done while busy", done_o, 0);
            check(rd_data_o[7] == status_of(op, w, exp_tog)[7],
                  (op == 2'd0) ? "R4 program bit7" : "R5 erase bit7",
                  rd_data_o, status_of(op, w, exp_tog));
            check(rd_data_o[6] == exp_tog, "R6 indicator bit", rd_data_o, status_of(op, w, exp_tog));
            check((rd_data_o & ~16'h00C0) == 0, "R8 other bits zero", rd_data_o, 0);
            if (poke)
                check(rd_data_o == status_of(op, w, exp_tog), "R3 start ignored", rd_data_o,
                      status_of(op, w, exp_tog));
            @(negedge clk);
            if (r) exp_tog = ~exp_tog;
        end
        start_i = 1'b0;
        rd_i = 1'b1;
        array_data_i = (op == 2'd0) ? w : 16'hFFFF;
        #1;
        check(!busy_o, "R2 busy ends after N cycles", busy_o, 0);
        check(done_o, "R10 done pulse", done_o, 1);
        check(rd_data_o == array_data_i, "R9 true data after completion", rd_data_o, array_data_i);
        @(negedge clk);
        rd_i = 1'b0;
        #1;
        check(!done_o, "R10 done single cycle", done_o, 0);
        check(!busy_o, "R7 stays idle", busy_o, 0);
    endtask

    initial begin
        #(200000 * 4);
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        #1;
        check(!busy_o, "R1 reset busy", busy_o, 0);
        check(!done_o, "R1 reset done", done_o, 0);
        @(negedge clk);
        rst_n = 1'b1;
        idle_cycles(4);
        // first busy read shows the reset value of the indicator (R1)
        @(negedge clk);
        start_i = 1'b1; op_i = 2'd1; prog_word_i = '0;
        @(negedge clk);
        start_i = 1'b0;
        #1;
        check(rd_data_o == 16'h0000, "R1 indicator resets to 0", rd_data_o, 0);
        repeat (NBLK) @(negedge clk);
        repeat (3) @(negedge clk);
        idle_cycles(3);
        // directed: program with bit7 set and clear, erases, starts during busy
        run_op(2'd0, 16'h1280, 1'b0);
        idle_cycles(7);
        run_op(2'd0, 16'hAB3C, 1'b1);
        idle_cycles(5);
        run_op(2'd1, 16'h00FF, 1'b1);
        idle_cycles(2);
        run_op(2'd2, 16'h5555, 1'b0);
        run_op(2'd3, 16'h0080, 1'b0);
        // random programs and sector erases
        for (int k = 0; k < 12; k++) begin
            run_op(2'($urandom_range(0, 1)), DW'($urandom), 1'($urandom));
            idle_cycles($urandom_range(0, 6));
        end
        finish_run();
    end
endmodule